// File: doc/BRIEF.md
# Dual-Read Bit-Slice Register File

This block holds eight words and gives one write port and two read ports that can all act in the same clock cycle. A write is set up while the clock is low and is committed on the rising edge. Each read port ends in its own output latch. The latch is open while the clock is high and closed while it is low, so each output stays steady through the low phase. A read of the location being written therefore cannot race the write.

An active-low slave-enable input forces both output latches open. Each output then follows its addressed word without regard to the clock. The word width is a parameter with a default of one bit. Wider words are built by placing slices side by side, with every address and control line shared. There is no reset and no separate write enable.

Top module: `rfslice_top`

## Requirements
- R1: On every rising clock edge, the word at `wrAddr` (3-bit binary, entries 0 to 7) takes the value of `wrData`. The other seven words keep their values. No write-enable input exists, so every rising edge is a write.
- R2: While the clock is high and `slvEnN` is 1, `rdDataB` equals the word addressed by `rdAddrB`.
- R3: While the clock is high and `slvEnN` is 1, `rdDataC` equals the word addressed by `rdAddrC`, independently of port B and of the write port.
- R4: While the clock is low and `slvEnN` is 1, each output keeps the value it had at the falling edge. Changes to its read address or to the write inputs have no effect on it.
- R5: When a read port addresses the location written on a rising edge, it shows the new value during the high phase that follows that edge.
- R6: While `slvEnN` is 0, each output follows its addressed word in either clock phase. This includes address changes made while the clock is low.
- R7: Each of the WIDTH data bits is stored and read independently. Mixed bit patterns come back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock: rising edge commits the write; the high phase opens the output latches |
| wrAddr | input | 3 | Write location select |
| wrData | input | WIDTH | Write data |
| rdAddrB | input | 3 | Read location select, port B |
| rdAddrC | input | 3 | Read location select, port C |
| slvEnN | input | 1 | Active-low: 0 holds both output latches open |
| rdDataB | output | WIDTH | Read data, port B |
| rdDataC | output | WIDTH | Read data, port C |

## Verification
A wrong write decode corrupts a word that is not being written. That error reaches a port in the high phase of the first later cycle in which the word is read, so the bench reads every location after each write across a full sweep of write and read addresses. A latch whose enable is wrong shows up within the same low phase: the bench moves the read address and the write inputs after the falling edge and expects no change on the output. With the slave enable asserted, it expects the output to follow the new address at once. Same-location read and write cycles check, in the first high phase, that the new word appears and not the old one.

// File: rtl/rfslice_pkg.sv
package rfslice_pkg;
  localparam int ENTRIES = 8;
  localparam int ADDR_W  = $clog2(ENTRIES);
  localparam int PORTS   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic [ENTRIES-1:0] wrSel;     // one-hot write select
    logic               slaveOpen; // output latches transparent
  } rfCtl_t;
endpackage

// File: rtl/rfslice_ctrl.sv
module rfslice_ctrl
  import rfslice_pkg::*;
(
  input  logic              clk,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              slvEnN,
  output rfCtl_t            ctl
);
  logic [ENTRIES-1:0] selVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_dec
    assign selVec[i] = (wrAddr == ADDR_W'(i));
  end

  always_comb begin
    ctl.wrSel     = selVec;
    ctl.slaveOpen = clk | ~slvEnN;
  end
endmodule

// File: rtl/rfslice_dp.sv
module rfslice_dp
  import rfslice_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic              clk,
  input  rfCtl_t            ctl,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr [PORTS],
  output logic [WIDTH-1:0]  rdData [PORTS]
);
  logic [WIDTH-1:0] rowVal [ENTRIES];

  // master storage: one word per entry
  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    logic [WIDTH-1:0] word;
    always_ff @(posedge clk) begin
      if (ctl.wrSel[i]) word <= wrData;
    end
    assign rowVal[i] = word;
  end

  // read select and slave latch per port
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [WIDTH-1:0] selWord;
    logic [WIDTH-1:0] slaveQ;
    assign selWord = rowVal[rdAddr[p]];
    always_latch begin
      if (ctl.slaveOpen) slaveQ <= selWord;
    end
    assign rdData[p] = slaveQ;
  end
endmodule

// File: rtl/rfslice_top.sv
module rfslice_top
  import rfslice_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] rdAddrC,
  input  logic              slvEnN,
  output logic [WIDTH-1:0]  rdDataB,
  output logic [WIDTH-1:0]  rdDataC
);
  rfCtl_t           ctl;
  logic [ADDR_W-1:0] rdAddrArr [PORTS];
  logic [WIDTH-1:0]  rdDataArr [PORTS];

  assign rdAddrArr[0] = rdAddrB;
  assign rdAddrArr[1] = rdAddrC;

  rfslice_ctrl uCtrl (
    .clk    (clk),
    .wrAddr (wrAddr),
    .slvEnN (slvEnN),
    .ctl    (ctl)
  );

  rfslice_dp #(.WIDTH(WIDTH)) uDp (
    .clk    (clk),
    .ctl    (ctl),
    .wrData (wrData),
    .rdAddr (rdAddrArr),
    .rdData (rdDataArr)
  );

  assign rdDataB = rdDataArr[0];
  assign rdDataC = rdDataArr[1];
endmodule

// File: rtl/rfslice_chk.sv
module rfslice_chk
  import rfslice_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input logic              clk,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [WIDTH-1:0]  wrData,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [ADDR_W-1:0] rdAddrC,
  input logic              slvEnN,
  input logic [WIDTH-1:0]  rdDataB,
  input logic [WIDTH-1:0]  rdDataC
);
  logic [WIDTH-1:0]   shadow [ENTRIES];
  logic [ENTRIES-1:0] known = '0;
  logic [WIDTH-1:0]   heldB, heldC;
  logic               armB = 1'b0;
  logic               armC = 1'b0;

  always_ff @(posedge clk) begin
    shadow[wrAddr] <= wrData;
    known[wrAddr]  <= 1'b1;
  end

  always_ff @(negedge clk) begin
    heldB <= rdDataB;
    heldC <= rdDataC;
    armB  <= slvEnN && known[rdAddrB];
    armC  <= slvEnN && known[rdAddrC];
  end

  // R2
  port_b_read_chk: assert property (@(negedge clk)
    known[rdAddrB] |-> rdDataB == shadow[rdAddrB]);

  // R3
  port_c_read_chk: assert property (@(negedge clk)
    known[rdAddrC] |-> rdDataC == shadow[rdAddrC]);

  // R4
  hold_b_chk: assert property (@(posedge clk)
    (armB && slvEnN) |-> rdDataB == heldB);

  // R4
  hold_c_chk: assert property (@(posedge clk)
    (armC && slvEnN) |-> rdDataC == heldC);

  // R6
  bypass_b_chk: assert property (@(posedge clk)
    (!slvEnN && known[rdAddrB]) |-> rdDataB == shadow[rdAddrB]);

  // R6
  bypass_c_chk: assert property (@(posedge clk)
    (!slvEnN && known[rdAddrC]) |-> rdDataC == shadow[rdAddrC]);
endmodule

bind rfslice_top rfslice_chk #(.WIDTH(WIDTH)) uChk (.*);

// File: tb/sim_rfslice_top.sv
module sim_rfslice_top;
  localparam int CLK_P = 20;
  localparam int W     = 4;

  logic         clk = 1'b0;
  logic [2:0]   wrAddr, rdAddrB, rdAddrC;
  logic [W-1:0] wrData;
  logic         slvEnN;
  logic [W-1:0] rdDataB, rdDataC;

  logic [W-1:0] model [8];
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  rfslice_top #(.WIDTH(W)) u0 (
    .clk(clk), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrB(rdAddrB), .rdAddrC(rdAddrC), .slvEnN(slvEnN),
    .rdDataB(rdDataB), .rdDataC(rdDataC)
  );

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // one full cycle starting and ending with clk low; checks the high phase
  task automatic step(input logic [2:0] wa, input logic [W-1:0] wd,
                      input logic [2:0] ba, input logic [2:0] ca,
                      input logic en, input bit chk);
    wrAddr = wa; wrData = wd; rdAddrB = ba; rdAddrC = ca; slvEnN = en;
    #(CLK_P/2);
    clk = 1'b1;
    model[wa] = wd;
    #(CLK_P/4);
    if (chk) begin
      // R2 / R5: port B sees the newly written word when addresses match
      check(ba == wa ? "R5 port B" : "R2 port B", rdDataB, model[ba]);
      check(ca == wa ? "R5 port C" : "R3 port C", rdDataC, model[ca]);
    end
    #(CLK_P/4);
    clk = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_P * 5000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [W-1:0] hb, hc;
    // R1: fill every entry, each rising edge writes
    for (int i = 0; i < 8; i++) step(3'(i), W'(i * 3 + 1), 3'(i), 3'(7 - i), 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(3'(i), W'(i * 3 + 1), 3'(i), 3'((i + 4) % 8), 1'b1, 1'b0);
      check("R1 fill B", rdDataB, W'(i * 3 + 1));
      check("R1 fill C", rdDataC, W'(((i + 4) % 8) * 3 + 1));
    end

    // sweep write x read addresses with hold checks in the low phase
    for (int wa = 0; wa < 8; wa++) begin
      for (int ba = 0; ba < 8; ba++) begin
        step(3'(wa), W'(wa * 5 + ba * 7 + 1), 3'(ba), 3'((ba + 3) % 8), 1'b1, 1'b1);
        hb = rdDataB; hc = rdDataC;
        // R4: disturb addresses and write inputs while clk low
        rdAddrB = 3'(ba) ^ 3'd5; rdAddrC = 3'(ba) ^ 3'd2;
        wrAddr = 3'(ba); wrData = ~model[ba];
        #2;
        check("R4 hold B", rdDataB, hb);
        check("R4 hold C", rdDataC, hc);
      end
    end

    // R1: every other word unchanged after a sweep of reads
    for (int i = 0; i < 8; i++) begin
      step(3'((i + 1) % 8), model[(i + 1) % 8], 3'(i), 3'(i), 1'b1, 1'b0);
      check("R1 others kept", rdDataB, model[i]);
    end

    // R6: transparent outputs follow addresses in the low phase
    for (int i = 0; i < 8; i++) begin
      step(3'(i), W'(15 - i), 3'(i), 3'((i + 2) % 8), 1'b0, 1'b1);
      rdAddrB = 3'((i + 5) % 8); rdAddrC = 3'((i + 6) % 8);
      #2;
      check("R6 bypass B", rdDataB, model[(i + 5) % 8]);
      check("R6 bypass C", rdDataC, model[(i + 6) % 8]);
    end

    // R7: independent bit patterns
    step(3'd2, 4'b1010, 3'd2, 3'd3, 1'b1, 1'b0);
    step(3'd3, 4'b0101, 3'd2, 3'd3, 1'b1, 1'b0);
    step(3'd4, 4'b1001, 3'd2, 3'd3, 1'b1, 1'b0);
    check("R7 bits B", rdDataB, 4'b1010);
    check("R7 bits C", rdDataC, 4'b0101);
    step(3'd5, 4'b0110, 3'd4, 3'd4, 1'b1, 1'b0);
    check("R7 bits mixed", rdDataB, 4'b1001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule